// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block drives a single DMA channel through a chain of descriptors held in memory. When a start pulse arrives, it takes the next-link address supplied by the register file and reads the eight-word descriptor found there. It checks the descriptor's valid flag, then splits the byte count into transfer units. It hands each unit to an external data mover through a start/done handshake. Once the last unit of a descriptor is done, it writes the descriptor's header back with the valid flag cleared and moves on to the address in the descriptor's next-link word.

A chain ends at the first descriptor whose valid flag is clear, and the channel then drops its active status. Each descriptor carries its own configuration. That configuration sets request pacing, peripheral direction, fixed source or destination addressing and the end-interrupt mask. The descriptor's interval word sets an idle gap between units. A chain normally masks the interrupt on every descriptor except the final one, so software sees one interrupt per chain. Software can reclaim consumed slots by scanning for cleared headers.

Top module: `ldc_chan_seq`

## Requirements
- R1: After reset, `chan_active`, `chan_err`, `end_irq`, `mem_req` and `xfer_start` are all low.
- R2: A `go` pulse while idle starts descriptor reads at `link_addr`. Words are read one per memory handshake at addresses base+0, +4, … +28. The word order is header, source, destination, byte count, configuration, interval, extension, next-link. The header is read first.
- R3: If the header read at the current link address has bit 0 clear, the channel reads no further words of it, issues no transfer, and returns to idle with `chan_active` low and `chan_err` low.
- R4: A byte count N is issued as ceil(N/UNIT_BYTES) single-cycle `xfer_start` pulses. Each unit is UNIT_BYTES long except the last, which carries the remainder.
- R5: Unit k uses source address src+k·UNIT_BYTES and destination dst+k·UNIT_BYTES. The source stays fixed when configuration bit 20 is set. The destination stays fixed when configuration bit 21 is set.
- R6: `xfer_to_periph` equals configuration bit 3 (1 means memory to peripheral, 0 means peripheral to memory).
- R7: When configuration bit 2 is set, a unit starts only in a cycle where `periph_req` is high. Otherwise the channel waits with `chan_active` high.
- R8: With interval word V, the next unit's `xfer_start` comes V+1 cycles after the cycle in which the previous unit's `xfer_done` is sampled. With V=0 it comes one cycle after.
- R9: After a descriptor's last unit, the header is written back to the descriptor's base address with bit 0 cleared and every other bit unchanged.
- R10: `end_irq` pulses for one cycle, in the cycle after the write-back is acknowledged, only when configuration bit 24 of that descriptor is clear.
- R11: After write-back, the next descriptor is read from the address in word 7 (next-link), so a chain runs in link order, not address order.
- R12: A valid descriptor with byte count 0 sets `chan_err`, clears `chan_active` and issues no transfer or write-back.
- R13: A memory error on any read, or `xfer_err` from the data mover, sets `chan_err` and clears `chan_active`. A later `go` clears `chan_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse; ignored while active |
| link_addr | input | 32 | Next-link address register value sampled on `go` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write (header write-back) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_err | input | 1 | Memory error, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| xfer_start | output | 1 | One-cycle unit start to the data mover |
| xfer_src | output | 32 | Unit source address |
| xfer_dst | output | 32 | Unit destination address |
| xfer_len | output | 32 | Unit byte length |
| xfer_to_periph | output | 1 | Direction, configuration bit 3 |
| xfer_cfg | output | 32 | Current descriptor configuration word |
| xfer_ext | output | 32 | Current descriptor extension word |
| xfer_done | input | 1 | Data mover finished the unit |
| xfer_err | input | 1 | Data mover failed the unit |
| periph_req | input | 1 | Peripheral request level for paced descriptors |
| end_irq | output | 1 | End-of-transfer interrupt pulse |
| chan_active | output | 1 | Channel enable status |
| chan_err | output | 1 | Channel error status |

## Verification
The write-back acknowledgement of one descriptor and the first header fetch of the next are handled on the same clock edge. At that edge the interrupt decision is registered and the fetch pointer moves to the next-link word together. The bench builds chains whose descriptors sit out of address order, with interrupts masked on all but the last. The memory model issues its write-back acknowledge right before the next read starts. The bench timestamps both events and requires the interrupt exactly one cycle after the final write-back and never after the earlier ones. It also requires each following header read to come from the linked address.

// File: rtl/ldc_pkg.sv
`timescale 1ns/1ps
package ldc_pkg;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  localparam int W_HDR  = 0;
  localparam int W_SRC  = 1;
  localparam int W_DST  = 2;
  localparam int W_CNT  = 3;
  localparam int W_CFG  = 4;
  localparam int W_IVL  = 5;
  localparam int W_EXT  = 6;
  localparam int W_LINK = 7;

  localparam int HDR_VALID     = 0;
  localparam int CFG_PACED     = 2;
  localparam int CFG_TO_PERIPH = 3;
  localparam int CFG_SRC_HOLD  = 20;
  localparam int CFG_DST_HOLD  = 21;
  localparam int CFG_IRQ_MASK  = 24;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_ISSUE, S_BUSY, S_GAP, S_WBACK
  } seq_state_t;

  function automatic logic [31:0] unit_bytes_of(input logic [31:0] left,
                                                input logic [31:0] cap);
    return (left < cap) ? left : cap;
  endfunction

  function automatic logic [31:0] step_addr(input logic [31:0] a,
                                            input logic [31:0] n,
                                            input logic hold);
    return hold ? a : a + n;
  endfunction

  function automatic logic [31:0] word_addr(input logic [31:0] base,
                                            input logic [IDX_W-1:0] idx);
    return base + {{(30-IDX_W){1'b0}}, idx, 2'b00};
  endfunction
endpackage

// File: rtl/ldc_desc_store.sv
`timescale 1ns/1ps
module ldc_desc_store #(
  parameter int NW = 8,
  parameter int DW = 32,
  localparam int IW = $clog2(NW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [DW-1:0]          wr_data,
  output logic [NW-1:0][DW-1:0]  words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= '0;
      else if (wr_en && (wr_idx == IW'(g)))      q <= wr_data;
    end
    assign words[g] = q;
  end
endmodule

// File: rtl/ldc_gap_timer.sv
`timescale 1ns/1ps
module ldc_gap_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] count,
  output logic          expire
);
  logic [CW-1:0] left_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (load)           left_q <= count;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end
  assign expire = (left_q == CW'(1));
endmodule

// File: rtl/ldc_unit_stepper.sv
`timescale 1ns/1ps
module ldc_unit_stepper
  import ldc_pkg::*;
#(
  parameter int UNIT_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] src_i,
  input  logic [31:0] dst_i,
  input  logic [31:0] cnt_i,
  input  logic        src_hold,
  input  logic        dst_hold,
  input  logic        advance,
  output logic [31:0] cur_src,
  output logic [31:0] cur_dst,
  output logic [31:0] cur_len,
  output logic        last_unit
);
  localparam logic [31:0] CAP = 32'(UNIT_BYTES);
  logic [31:0] left_q;

  assign cur_len   = unit_bytes_of(left_q, CAP);
  assign last_unit = (left_q <= CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      cur_src <= '0;
      cur_dst <= '0;
    end else if (load) begin
      left_q  <= cnt_i;
      cur_src <= src_i;
      cur_dst <= dst_i;
    end else if (advance) begin
      left_q  <= left_q - cur_len;
      cur_src <= step_addr(cur_src, cur_len, src_hold);
      cur_dst <= step_addr(cur_dst, cur_len, dst_hold);
    end
  end
endmodule

// File: rtl/ldc_chan_seq.sv
`timescale 1ns/1ps
module ldc_chan_seq
  import ldc_pkg::*;
#(
  parameter int UNIT_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] link_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        xfer_start,
  output logic [31:0] xfer_src,
  output logic [31:0] xfer_dst,
  output logic [31:0] xfer_len,
  output logic        xfer_to_periph,
  output logic [31:0] xfer_cfg,
  output logic [31:0] xfer_ext,
  input  logic        xfer_done,
  input  logic        xfer_err,
  input  logic        periph_req,
  output logic        end_irq,
  output logic        chan_active,
  output logic        chan_err
);
  logic [DESC_WORDS-1:0][31:0] dw;
  seq_state_t                  st;
  logic [31:0]                 ptr;
  logic [IDX_W-1:0]            widx;
  logic                        active_q, err_q, irq_q;

  // named internal events
  logic fetch_ok, hdr_invalid, desc_loaded, mem_fault, wb_done;
  logic unit_done, xfer_fault, issue_fire, zero_count, step_load;
  logic gap_busy, gap_expire, paced_w, last_unit;

  assign paced_w     = dw[W_CFG][CFG_PACED];
  assign fetch_ok    = (st == S_FETCH) && mem_ack && !mem_err;
  assign hdr_invalid = fetch_ok && (widx == IDX_W'(W_HDR)) && !mem_rdata[HDR_VALID];
  assign desc_loaded = fetch_ok && (widx == IDX_W'(W_LINK));
  assign mem_fault   = ((st == S_FETCH) || (st == S_WBACK)) && mem_ack && mem_err;
  assign wb_done     = (st == S_WBACK) && mem_ack && !mem_err;
  assign unit_done   = (st == S_BUSY) && xfer_done && !xfer_err;
  assign xfer_fault  = (st == S_BUSY) && xfer_err;
  assign issue_fire  = (st == S_ISSUE) && (!paced_w || periph_req);
  assign zero_count  = (st == S_CHECK) && (dw[W_CNT] == '0);
  assign step_load   = (st == S_CHECK) && !zero_count;
  assign gap_busy    = (st == S_GAP);

  ldc_desc_store #(.NW(DESC_WORDS), .DW(32)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fetch_ok),
    .wr_idx  (widx),
    .wr_data (mem_rdata),
    .words   (dw)
  );

  ldc_unit_stepper #(.UNIT_BYTES(UNIT_BYTES)) step_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (step_load),
    .src_i     (dw[W_SRC]),
    .dst_i     (dw[W_DST]),
    .cnt_i     (dw[W_CNT]),
    .src_hold  (dw[W_CFG][CFG_SRC_HOLD]),
    .dst_hold  (dw[W_CFG][CFG_DST_HOLD]),
    .advance   (unit_done),
    .cur_src   (xfer_src),
    .cur_dst   (xfer_dst),
    .cur_len   (xfer_len),
    .last_unit (last_unit)
  );

  ldc_gap_timer #(.CW(32)) gap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (unit_done),
    .count  (dw[W_IVL]),
    .expire (gap_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr      <= '0;
      widx     <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          ptr      <= link_addr;
          widx     <= '0;
          active_q <= 1'b1;
          err_q    <= 1'b0;
          st       <= S_FETCH;
        end
        S_FETCH: begin
          if (mem_fault) begin
            err_q <= 1'b1; active_q <= 1'b0; st <= S_IDLE;
          end else if (hdr_invalid) begin
            active_q <= 1'b0; st <= S_IDLE;
          end else if (desc_loaded) begin
            st <= S_CHECK;
          end else if (fetch_ok) begin
            widx <= widx + 1'b1;
          end
        end
        S_CHECK: begin
          if (zero_count) begin
            err_q <= 1'b1; active_q <= 1'b0; st <= S_IDLE;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: if (issue_fire) st <= S_BUSY;
        S_BUSY: begin
          if (xfer_fault) begin
            err_q <= 1'b1; active_q <= 1'b0; st <= S_IDLE;
          end else if (unit_done) begin
            if (last_unit)              st <= S_WBACK;
            else if (dw[W_IVL] != '0)   st <= S_GAP;
            else                        st <= S_ISSUE;
          end
        end
        S_GAP: if (gap_expire) st <= S_ISSUE;
        S_WBACK: begin
          if (mem_fault) begin
            err_q <= 1'b1; active_q <= 1'b0; st <= S_IDLE;
          end else if (wb_done) begin
            irq_q <= !dw[W_CFG][CFG_IRQ_MASK];
            ptr   <= dw[W_LINK];
            widx  <= '0;
            st    <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req        = (st == S_FETCH) || (st == S_WBACK);
  assign mem_we         = (st == S_WBACK);
  assign mem_addr       = (st == S_WBACK) ? ptr : word_addr(ptr, widx);
  assign mem_wdata      = dw[W_HDR] & ~(32'd1 << HDR_VALID);
  assign xfer_start     = issue_fire;
  assign xfer_to_periph = dw[W_CFG][CFG_TO_PERIPH];
  assign xfer_cfg       = dw[W_CFG];
  assign xfer_ext       = dw[W_EXT];
  assign end_irq        = irq_q;
  assign chan_active    = active_q;
  assign chan_err       = err_q;
endmodule

// File: rtl/ldc_chan_seq_chk.sv
`timescale 1ns/1ps
module ldc_chan_seq_chk #(
  parameter int UNIT_BYTES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic        xfer_start,
  input logic [31:0] xfer_len,
  input logic        end_irq,
  input logic        chan_active,
  input logic        chan_err,
  input logic        gap_busy
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |-> (!mem_req && !xfer_start));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_unit_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> ((xfer_len != 32'd0) && (xfer_len <= 32'(UNIT_BYTES))));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_gap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> !xfer_start);

  assert_irq_after_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> $past(mem_ack && mem_we && !mem_err));

  assert_err_halts_R13: assert property (@(posedge clk) disable iff (!rst_n)
    chan_err |-> !chan_active);
endmodule

bind ldc_chan_seq ldc_chan_seq_chk #(.UNIT_BYTES(UNIT_BYTES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_we      (mem_we),
  .mem_err     (mem_err),
  .mem_addr    (mem_addr),
  .xfer_start  (xfer_start),
  .xfer_len    (xfer_len),
  .end_irq     (end_irq),
  .chan_active (chan_active),
  .chan_err    (chan_err),
  .gap_busy    (gap_busy)
);

// File: tb/ldc_chan_seq_tb_top.sv
`timescale 1ns/1ps
module ldc_chan_seq_tb_top;
  localparam int UNIT = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, go, mem_ack, mem_err, xfer_done, xfer_err, periph_req;
  logic [31:0] link_addr, mem_rdata;
  logic        mem_req, mem_we, xfer_start, xfer_to_periph, end_irq, chan_active, chan_err;
  logic [31:0] mem_addr, mem_wdata, xfer_src, xfer_dst, xfer_len, xfer_cfg, xfer_ext;

  ldc_chan_seq #(.UNIT_BYTES(UNIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .link_addr(link_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_len(xfer_len),
    .xfer_to_periph(xfer_to_periph), .xfer_cfg(xfer_cfg), .xfer_ext(xfer_ext),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .periph_req(periph_req),
    .end_irq(end_irq), .chan_active(chan_active), .chan_err(chan_err)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:255];
  int cyc = 0, done_cyc = 0, eng_cnt = 0, wb_cyc = -10;
  logic inj_xerr = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFFC;
  logic [31:0] rec_src [0:63];
  logic [31:0] rec_dst [0:63];
  logic [31:0] rec_len [0:63];
  logic        rec_dir [0:63];
  int          rec_gap [0:63];
  logic [31:0] wb_addr [0:15];
  logic [31:0] wb_data [0:15];
  int n_rec, n_wb, n_rd, irq_cnt, irq_bad;
  logic [31:0] first_rd;

  // memory model, data mover stub and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (end_irq) begin
      irq_cnt++;
      if (cyc != wb_cyc + 1) irq_bad++;
    end
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        if (n_wb < 16) begin wb_addr[n_wb] = mem_addr; wb_data[n_wb] = mem_wdata; end
        n_wb++;
        wb_cyc = cyc;
      end else begin
        if (n_rd == 0) first_rd = mem_addr;
        n_rd++;
        mem_err   = (mem_addr == err_addr);
        mem_rdata = mem[mem_addr[9:2]];
      end
    end
    xfer_done = 1'b0;
    xfer_err  = 1'b0;
    if (xfer_start) begin
      if (n_rec < 64) begin
        rec_src[n_rec] = xfer_src; rec_dst[n_rec] = xfer_dst;
        rec_len[n_rec] = xfer_len; rec_dir[n_rec] = xfer_to_periph;
        rec_gap[n_rec] = cyc - done_cyc;
      end
      n_rec++;
      eng_cnt = 2;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        if (inj_xerr) xfer_err = 1'b1; else xfer_done = 1'b1;
        done_cyc = cyc;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int s, input logic [31:0] h, sa, da, n, cf, iv, lk);
    mem[s*8+0] = h;  mem[s*8+1] = sa; mem[s*8+2] = da; mem[s*8+3] = n;
    mem[s*8+4] = cf; mem[s*8+5] = iv; mem[s*8+6] = 32'h0; mem[s*8+7] = lk;
  endtask

  task automatic launch(input logic [31:0] la);
    n_rec = 0; n_wb = 0; n_rd = 0; irq_cnt = 0; irq_bad = 0; first_rd = 32'hX;
    @(negedge clk); #1 link_addr = la; go = 1'b1;
    @(negedge clk); #1 go = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (chan_active && k < 4000) begin @(negedge clk); k++; end
    if (chan_active) begin
      n_chk++; n_bad++;
      $display("FAIL run watchdog: actual busy expected idle");
    end
    @(negedge clk);
  endtask

  task automatic check_units(input int first, input logic [31:0] n, sa, da, cf);
    int cnt = int'((n + UNIT - 1) / UNIT);
    for (int k = 0; k < cnt; k++) begin
      logic [31:0] el, es, ed, rem;
      rem = n - 32'(k * UNIT);
      el  = (rem < UNIT) ? rem : 32'(UNIT);
      es  = cf[20] ? sa : sa + 32'(k * UNIT);
      ed  = cf[21] ? da : da + 32'(k * UNIT);
      chk("R4", "unit length", rec_len[first+k], el);
      chk("R5", "unit source", rec_src[first+k], es);
      chk("R5", "unit destination", rec_dst[first+k], ed);
      chk("R6", "direction", 32'(rec_dir[first+k]), 32'(cf[3]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL global watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; periph_req = 1'b0; link_addr = '0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0; xfer_done = 1'b0; xfer_err = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "chan_active", 32'(chan_active), 0);
    chk("R1", "chan_err", 32'(chan_err), 0);
    chk("R1", "end_irq", 32'(end_irq), 0);
    chk("R1", "mem_req", 32'(mem_req), 0);
    chk("R1", "xfer_start", 32'(xfer_start), 0);

    // length sweep, one descriptor at slot 0, link to empty slot 1
    for (int L = 1; L <= 48; L++) begin
      logic [31:0] h, sa, da, cf;
      h  = 32'h5A00_0001 | (32'(L) << 8);
      sa = 32'h1000_0000 + 32'(L * 256);
      da = 32'h2000_0000 + 32'(L * 512);
      cf = 32'h8000_0000 | ((L % 2 == 1) ? 32'h0010_0000 : 0)
                         | ((L % 3 == 0) ? 32'h0020_0000 : 0)
                         | ((L % 4 == 0) ? 32'h0000_0008 : 0);
      put_desc(0, h, sa, da, 32'(L), cf, 0, 32'd32);
      launch(32'd0);
      wait_idle();
      chk("R2", "first read address", first_rd, 32'd0);
      chk("R11", "reads incl. next header", 32'(n_rd), 32'd9);
      chk("R4", "unit count", 32'(n_rec), 32'((L + UNIT - 1) / UNIT));
      check_units(0, 32'(L), sa, da, cf);
      chk("R9", "write-back count", 32'(n_wb), 1);
      chk("R9", "write-back address", wb_addr[0], 32'd0);
      chk("R9", "write-back header", wb_data[0], h & 32'hFFFF_FFFE);
      chk("R10", "irq count", 32'(irq_cnt), 1);
      chk("R10", "irq timing", 32'(irq_bad), 0);
      chk("R13", "no error", 32'(chan_err), 0);
    end

    // interval sweep
    for (int V = 0; V <= 5; V++) begin
      put_desc(0, 32'h1, 32'h3000_0000, 32'h4000_0000, 32'd48, 32'h8000_0000, 32'(V), 32'd32);
      launch(32'd0);
      wait_idle();
      chk("R8", "units", 32'(n_rec), 3);
      chk("R8", "gap unit1", 32'(rec_gap[1]), 32'(V + 1));
      chk("R8", "gap unit2", 32'(rec_gap[2]), 32'(V + 1));
    end

    // chain out of address order: 2 -> 5 -> 3 -> 9 (empty)
    put_desc(2, 32'hA001, 32'h5000_0000, 32'h6000_0000, 32'd20, 32'h8120_0008, 0, 32'd160);
    put_desc(5, 32'hB001, 32'h5100_0000, 32'h6100_0000, 32'd16, 32'h8100_0000, 32'd2, 32'd96);
    put_desc(3, 32'hC001, 32'h5200_0000, 32'h6200_0000, 32'd33, 32'h8010_0000, 32'd1, 32'd288);
    launch(32'd64);
    wait_idle();
    chk("R2", "chain first read", first_rd, 32'd64);
    chk("R11", "chain reads", 32'(n_rd), 32'd25);
    chk("R4", "chain units", 32'(n_rec), 6);
    check_units(0, 32'd20, 32'h5000_0000, 32'h6000_0000, 32'h8120_0008);
    check_units(2, 32'd16, 32'h5100_0000, 32'h6100_0000, 32'h8100_0000);
    check_units(3, 32'd33, 32'h5200_0000, 32'h6200_0000, 32'h8010_0000);
    chk("R11", "write-back count", 32'(n_wb), 3);
    chk("R11", "write-back 0 addr", wb_addr[0], 32'd64);
    chk("R11", "write-back 1 addr", wb_addr[1], 32'd160);
    chk("R11", "write-back 2 addr", wb_addr[2], 32'd96);
    chk("R9", "slot 5 header cleared", mem[40], 32'hB000);
    chk("R10", "only final irq", 32'(irq_cnt), 1);
    chk("R10", "irq timing", 32'(irq_bad), 0);

    // invalid descriptor at start (slot 12 empty)
    launch(32'd384);
    wait_idle();
    chk("R3", "no units", 32'(n_rec), 0);
    chk("R3", "header only", 32'(n_rd), 1);
    chk("R3", "no error", 32'(chan_err), 0);
    chk("R3", "inactive", 32'(chan_active), 0);
    chk("R3", "no irq", 32'(irq_cnt), 0);

    // zero byte count
    put_desc(13, 32'h1, 32'h7000_0000, 32'h7100_0000, 32'd0, 32'h8000_0000, 0, 32'd32);
    launch(32'd416);
    wait_idle();
    chk("R12", "error set", 32'(chan_err), 1);
    chk("R12", "no units", 32'(n_rec), 0);
    chk("R12", "no write-back", 32'(n_wb), 0);
    chk("R12", "inactive", 32'(chan_active), 0);

    // memory error on the configuration word
    put_desc(14, 32'h1, 32'h7200_0000, 32'h7300_0000, 32'd8, 32'h8000_0000, 0, 32'd32);
    err_addr = 32'd464;
    launch(32'd448);
    wait_idle();
    err_addr = 32'hFFFF_FFFC;
    chk("R13", "fetch error flag", 32'(chan_err), 1);
    chk("R13", "fetch stopped", 32'(n_rd), 5);
    chk("R13", "no units", 32'(n_rec), 0);

    // data mover error
    put_desc(15, 32'h1, 32'h7400_0000, 32'h7500_0000, 32'd40, 32'h8000_0000, 0, 32'd32);
    inj_xerr = 1'b1;
    launch(32'd480);
    wait_idle();
    inj_xerr = 1'b0;
    chk("R13", "mover error flag", 32'(chan_err), 1);
    chk("R13", "one unit", 32'(n_rec), 1);
    chk("R13", "no write-back", 32'(n_wb), 0);
    chk("R13", "no irq", 32'(irq_cnt), 0);

    // paced descriptor
    put_desc(16, 32'h1, 32'h7600_0000, 32'h7700_0000, 32'd32, 32'h8000_0004, 0, 32'd544);
    launch(32'd512);
    repeat (40) @(negedge clk);
    chk("R7", "held without request", 32'(n_rec), 0);
    chk("R7", "still active", 32'(chan_active), 1);
    chk("R13", "go cleared error", 32'(chan_err), 0);
    @(posedge clk); #1 periph_req = 1'b1;
    wait_idle();
    periph_req = 1'b0;
    chk("R7", "units after request", 32'(n_rec), 2);
    check_units(0, 32'd32, 32'h7600_0000, 32'h7700_0000, 32'h8000_0004);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule